// File: doc/BRIEF.md
# Configurable Lookup Logic Cell with Carry and Cascade Links

This block is one configurable logic cell. A 16-entry, one-bit-wide truth table is indexed by four data inputs. Its result can leave the cell directly or through a storage flop. That flop has asynchronous clear and preset, a clock enable, and synchronous clear and load. Two dedicated links join a cell to its neighbours without any general routing. The carry link passes a ripple carry for adders and counters. The cascade link merges the local result with the previous cell's result through an AND or an OR, so that wide functions can be built.

The truth table and four mode bits form one 20-bit configuration word. The word is loaded serially before use while a load strobe is held high. A fabric of such cells chains `cout` into the next `cin` and `casc_out` into the next `casc_in`.

The chip-wide active-low reset takes effect at once and is released through a two-stage synchronizer. It clears both the configuration and the flop.

Top module: `lut_logic_cell`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into the low end of the 20-bit configuration word, so the first bit sent ends up in bit 19 (most significant bit first). Word layout: bits [19:4] are the table, with table entry k at word bit 4+k. Bit 3 selects arithmetic mode, bit 2 enables cascading, bit 1 picks OR (1) or AND (0) for the cascade, and bit 0 selects register bypass.
- R2: While `cfg_en` is low, the configuration word holds and `cfg_din` has no effect on the cell's function.
- R3: In logic mode (bit 3 = 0), the local result is table entry `{d[3],d[2],d[1],d[0]}`, and `cout` is 0.
- R4: In arithmetic mode (bit 3 = 1), the local result is `d[0] ^ d[1] ^ cin` and `cout` is the majority of `d[0]`, `d[1]` and `cin`. The table contents have no effect in this mode.
- R5: With cascading disabled, `casc_in` has no effect. With it enabled, the combined result is the local result ANDed (bit 1 = 0) or ORed (bit 1 = 1) with `casc_in`. `casc_out` always carries the combined result.
- R6: With bypass set, `q_out` follows the combined result without a clock. With bypass clear, `q_out` is the flop output.
- R7: With `ena` high, the flop takes the combined result on a rising edge. With `ena` low, it holds.
- R8: With `ena` high, `sclr` clears the flop on the edge and wins over `sload`. `sload` on its own loads `sdata`.
- R9: `aclr` clears the flop at once, without a clock edge, and wins over `apre`.
- R10: `apre` sets the flop at once and wins over the clock enable and the synchronous controls.
- R11: `rst_n` low clears the flop and the configuration word at once. After `rst_n` rises, operation resumes within three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip-wide asynchronous reset, active low |
| cfg_en | input | 1 | Configuration shift strobe |
| cfg_din | input | 1 | Configuration serial data, MSB first |
| d | input | 4 | Table index / addend inputs |
| cin | input | 1 | Carry from the previous cell |
| casc_in | input | 1 | Cascade value from the previous cell |
| ena | input | 1 | Flop clock enable |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of `sdata` |
| sdata | input | 1 | Synchronous load value |
| aclr | input | 1 | Asynchronous clear, active high |
| apre | input | 1 | Asynchronous preset, active high |
| q_out | output | 1 | Cell output (flop or bypass) |
| cout | output | 1 | Carry to the next cell |
| casc_out | output | 1 | Cascade value to the next cell |

## Verification
The bench builds every cell with the default four table inputs, so the whole 16-entry table can be swept exhaustively for two distinct contents. One standalone cell exercises the flop controls and the orderings between them. A row of four chained cells turns the carry link into a 4-bit ripple adder. The same row is reloaded as a 16-input AND and as a 16-input OR built from the cascade link. This reaches carries that ripple across the full row, and shows that a disabled head cell ignores its own `casc_in`.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef struct packed {
    logic arith;
    logic casc_en;
    logic casc_or;
    logic bypass;
  } lc_mode_t;

  localparam int unsigned MODE_W = $bits(lc_mode_t);

endpackage

// File: rtl/lc_rst_sync.sv
module lc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/lc_cfg_shift.sv
module lc_cfg_shift #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic [W-1:0] word
);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (cfg_en) word_d = {word_q[W-2:0], cfg_din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

endmodule

// File: rtl/lc_func.sv
module lc_func
  import lc_pkg::*;
#(
  parameter int unsigned LUT_IN = 4,
  localparam int unsigned TBL_W = 1 << LUT_IN
) (
  input  logic [TBL_W-1:0]  tbl,
  input  lc_mode_t          mode,
  input  logic [LUT_IN-1:0] d,
  input  logic              cin,
  input  logic              casc_in,
  output logic              comb,
  output logic              cout
);

  logic lut_bit;
  logic sum_bit;
  logic maj_bit;
  logic local_bit;

  always_comb begin
    lut_bit   = tbl[d];
    sum_bit   = d[0] ^ d[1] ^ cin;
    maj_bit   = (d[0] & d[1]) | (d[0] & cin) | (d[1] & cin);
    local_bit = mode.arith ? sum_bit : lut_bit;
    cout      = mode.arith ? maj_bit : 1'b0;
  end

  always_comb begin
    unique case ({mode.casc_en, mode.casc_or})
      2'b10:   comb = local_bit & casc_in;
      2'b11:   comb = local_bit | casc_in;
      default: comb = local_bit;
    endcase
  end

endmodule

// File: rtl/lc_reg.sv
module lc_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic aclr,
  input  logic apre,
  input  logic ena,
  input  logic sclr,
  input  logic sload,
  input  logic sdata,
  input  logic dval,
  output logic q
);

  logic q_r;
  logic q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (ena) begin
      if (sclr)       q_nxt = 1'b0;
      else if (sload) q_nxt = sdata;
      else            q_nxt = dval;
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge aclr or posedge apre) begin
    if (!rst_n)     q_r <= 1'b0;
    else if (aclr)  q_r <= 1'b0;
    else if (apre)  q_r <= 1'b1;
    else            q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
  import lc_pkg::*;
#(
  parameter int unsigned LUT_IN     = 4,
  parameter int unsigned SYNC_STAGE = 2,
  localparam int unsigned TBL_W = 1 << LUT_IN,
  localparam int unsigned CFG_W = TBL_W + MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_din,
  input  logic [LUT_IN-1:0] d,
  input  logic              cin,
  input  logic              casc_in,
  input  logic              ena,
  input  logic              sclr,
  input  logic              sload,
  input  logic              sdata,
  input  logic              aclr,
  input  logic              apre,
  output logic              q_out,
  output logic              cout,
  output logic              casc_out
);

  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg_word;
  lc_mode_t         mode;
  logic [TBL_W-1:0] tbl;
  logic             comb;
  logic             reg_q;

  lc_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lc_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .word    (cfg_word)
  );

  assign tbl  = cfg_word[CFG_W-1:MODE_W];
  assign mode = lc_mode_t'(cfg_word[MODE_W-1:0]);

  lc_func #(.LUT_IN(LUT_IN)) u_func (
    .tbl     (tbl),
    .mode    (mode),
    .d       (d),
    .cin     (cin),
    .casc_in (casc_in),
    .comb    (comb),
    .cout    (cout)
  );

  lc_reg u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .aclr  (aclr),
    .apre  (apre),
    .ena   (ena),
    .sclr  (sclr),
    .sload (sload),
    .sdata (sdata),
    .dval  (comb),
    .q     (reg_q)
  );

  assign casc_out = comb;
  assign q_out    = mode.bypass ? comb : reg_q;

endmodule

// File: rtl/lc_cell_chk.sv
module lc_cell_chk #(
  parameter int unsigned LUT_IN = 4,
  parameter int unsigned CFG_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aclr,
  input logic              apre,
  input logic              ena,
  input logic              cfg_en,
  input logic              cfg_din,
  input logic [LUT_IN-1:0] d,
  input logic              cin,
  input logic              cout,
  input logic [CFG_W-1:0]  cfg_word,
  input logic              reg_q
);

  AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_word == {$past(cfg_word[CFG_W-2:0]), $past(cfg_din)})); // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_word)); // R2

  AST_ARITH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[3] |-> (cout == ((d[0] & d[1]) | (d[0] & cin) | (d[1] & cin)))); // R4

  AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena && !aclr && !apre) ##1 (!aclr && !apre) |-> $stable(reg_q)); // R7

  AST_ACLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    aclr |-> (reg_q == 1'b0)); // R9

  AST_APRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (apre && !aclr) |-> (reg_q == 1'b1)); // R10

endmodule

bind lut_logic_cell lc_cell_chk #(.LUT_IN(LUT_IN), .CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .aclr     (aclr),
  .apre     (apre),
  .ena      (ena),
  .cfg_en   (cfg_en),
  .cfg_din  (cfg_din),
  .d        (d),
  .cin      (cin),
  .cout     (cout),
  .cfg_word (cfg_word),
  .reg_q    (reg_q)
);

// File: tb/tb_lut_logic_cell.sv
module tb_lut_logic_cell;

  localparam int unsigned NCH = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // standalone cell
  logic       cfg_en, cfg_din, cin, casc_in, ena, sclr, sload, sdata, aclr, apre;
  logic [3:0] d;
  logic       q_out, cout, casc_out;

  lut_logic_cell dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .d(d),
    .cin(cin), .casc_in(casc_in), .ena(ena), .sclr(sclr), .sload(sload),
    .sdata(sdata), .aclr(aclr), .apre(apre), .q_out(q_out), .cout(cout),
    .casc_out(casc_out)
  );

  // chained row
  logic                      ch_cfg_en;
  logic [NCH-1:0]            ch_din;
  logic [NCH-1:0][3:0]       ch_d;
  logic                      ch_cin0, ch_casc0;
  logic [NCH-1:0]            ch_cin, ch_cascin, ch_q, ch_cout, ch_casc;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    if (k == 0) begin : g_head
      assign ch_cin[k]    = ch_cin0;
      assign ch_cascin[k] = ch_casc0;
    end else begin : g_link
      assign ch_cin[k]    = ch_cout[k-1];
      assign ch_cascin[k] = ch_casc[k-1];
    end
    lut_logic_cell u_cell (
      .clk(clk), .rst_n(rst_n), .cfg_en(ch_cfg_en), .cfg_din(ch_din[k]),
      .d(ch_d[k]), .cin(ch_cin[k]), .casc_in(ch_cascin[k]), .ena(1'b0),
      .sclr(1'b0), .sload(1'b0), .sdata(1'b0), .aclr(1'b0), .apre(1'b0),
      .q_out(ch_q[k]), .cout(ch_cout[k]), .casc_out(ch_casc[k])
    );
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_dut(input logic [19:0] w);
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk); cfg_en = 1'b1; cfg_din = w[i];
    end
    @(negedge clk); cfg_en = 1'b0;
  endtask

  task automatic load_chain(input logic [NCH-1:0][19:0] w);
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk);
      ch_cfg_en = 1'b1;
      for (int k = 0; k < NCH; k++) ch_din[k] = w[k][i];
    end
    @(negedge clk); ch_cfg_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check(q_out == 1'b0, "R11 reset q_out", q_out, 0);
    check(casc_out == 1'b0 && cout == 1'b0, "R11 reset links", {casc_out, cout}, 0);
  endtask

  task automatic t_table(input logic [15:0] tbl);
    load_dut({tbl, 4'b0001});
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); d = 4'(a); #1;
      check(q_out == tbl[a], "R3/R6 table lookup", q_out, tbl[a]);
    end
  endtask

  task automatic t_cfg_idle;
    load_dut({16'h0001, 4'b0001});
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); cfg_din = 1'(i % 2);
    end
    @(negedge clk); d = 4'h0; #1;
    check(q_out == 1'b1, "R2 cfg idle addr0", q_out, 1);
    @(negedge clk); d = 4'h5; #1;
    check(q_out == 1'b0, "R2 cfg idle addr5", q_out, 0);
    @(negedge clk); cin = 1'b1; d = 4'h3; #1;
    check(cout == 1'b0, "R3 logic mode cout", cout, 0);
    cin = 1'b0;
  endtask

  task automatic t_register;
    load_dut({16'h6996, 4'b0000});
    @(negedge clk); d = 4'h1; ena = 1'b1;
    @(negedge clk); #1;
    check(q_out == 1'b1, "R7 load on edge", q_out, 1);
    ena = 1'b0; d = 4'h0;
    @(negedge clk); #1;
    check(q_out == 1'b1, "R7 hold with ena low", q_out, 1);
    ena = 1'b1; sclr = 1'b1; sload = 1'b1; sdata = 1'b1; d = 4'h1;
    @(negedge clk); #1;
    check(q_out == 1'b0, "R8 sclr over sload", q_out, 0);
    sclr = 1'b0; d = 4'h0;
    @(negedge clk); #1;
    check(q_out == 1'b1, "R8 sload sdata", q_out, 1);
    sload = 1'b0; ena = 1'b0;
  endtask

  task automatic t_async;
    @(negedge clk); aclr = 1'b1; apre = 1'b1; #1;
    check(q_out == 1'b0, "R9 aclr immediate over apre", q_out, 0);
    @(negedge clk); aclr = 1'b0; apre = 1'b0;
    ena = 1'b1; d = 4'h0;
    @(negedge clk); apre = 1'b1; #1;
    check(q_out == 1'b1, "R10 apre immediate", q_out, 1);
    @(negedge clk); #1;
    check(q_out == 1'b1, "R10 apre over ena", q_out, 1);
    apre = 1'b0;
    @(negedge clk); #1;
    check(q_out == 1'b0, "R7 load after preset", q_out, 0);
    ena = 1'b0;
  endtask

  task automatic t_adder(input logic [15:0] tbl);
    logic [NCH-1:0][19:0] w;
    for (int k = 0; k < NCH; k++) w[k] = {tbl, 4'b1001};
    load_chain(w);
    for (int p = 0; p < 6; p++) begin
      logic [3:0] a, b;
      logic       c;
      logic [4:0] e;
      case (p)
        0: begin a = 4'h0; b = 4'h0; c = 1'b0; end
        1: begin a = 4'hF; b = 4'h1; c = 1'b0; end
        2: begin a = 4'hF; b = 4'hF; c = 1'b1; end
        3: begin a = 4'h5; b = 4'hA; c = 1'b1; end
        4: begin a = 4'h7; b = 4'h6; c = 1'b0; end
        default: begin a = 4'h9; b = 4'h3; c = 1'b1; end
      endcase
      e = 5'(a) + 5'(b) + 5'(c);
      @(negedge clk);
      ch_cin0 = c;
      for (int k = 0; k < NCH; k++) ch_d[k] = {2'b00, b[k], a[k]};
      #1;
      check({ch_cout[NCH-1], ch_q} == e, "R4 ripple sum", {ch_cout[NCH-1], ch_q}, e);
    end
    ch_cin0 = 1'b0;
  endtask

  task automatic t_cascade(input bit use_or);
    logic [NCH-1:0][19:0] w;
    logic [15:0] tbl;
    tbl = use_or ? 16'hFFFE : 16'h8000;
    w[0] = {tbl, 4'b0001};
    for (int k = 1; k < NCH; k++) w[k] = {tbl, use_or ? 4'b0111 : 4'b0101};
    load_chain(w);
    @(negedge clk);
    for (int k = 0; k < NCH; k++) ch_d[k] = use_or ? 4'h0 : 4'hF;
    ch_casc0 = use_or ? 1'b1 : 1'b0;
    #1;
    check(ch_casc[NCH-1] == !use_or, "R5 uniform inputs, head casc_in ignored",
          ch_casc[NCH-1], !use_or);
    check(ch_q[NCH-1] == ch_casc[NCH-1], "R6 bypass matches cascade", ch_q[NCH-1], ch_casc[NCH-1]);
    @(negedge clk);
    ch_d[2] = use_or ? 4'h4 : 4'hB;
    #1;
    check(ch_casc[NCH-1] == use_or, "R5 one input flipped", ch_casc[NCH-1], use_or);
    ch_casc0 = 1'b0;
  endtask

  task automatic t_rst_mid;
    load_dut({16'hFFFF, 4'b0000});
    @(negedge clk); ena = 1'b1;
    @(negedge clk); #1;
    check(q_out == 1'b1, "R7 preload before reset", q_out, 1);
    rst_n = 1'b0; #1;
    check(q_out == 1'b0, "R11 async reset", q_out, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(q_out == 1'b0, "R11 config cleared", q_out, 0);
    ena = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_en = 0; cfg_din = 0; cin = 0; casc_in = 0; ena = 0; sclr = 0;
    sload = 0; sdata = 0; aclr = 0; apre = 0; d = '0;
    ch_cfg_en = 0; ch_din = '0; ch_d = '0; ch_cin0 = 0; ch_casc0 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_table(16'h6996);   // R1 R3 parity table
    t_table(16'hA5C3);   // R1 R3 irregular table
    t_cfg_idle();        // R2
    t_register();        // R7 R8
    t_async();           // R9 R10
    t_adder(16'h0000);   // R4
    t_adder(16'hFFFF);   // R4 table ignored
    t_cascade(1'b0);     // R5 AND
    t_cascade(1'b1);     // R5 OR
    t_rst_mid();         // R11
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule